// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual page number into a physical page number by fetching one page table entry from memory. A walk request carries the virtual page number, the page offset and the kind of access (load, store or instruction fetch). The walker forms the entry address from a table base register and the page number, issues one read on a simple valid/ready memory port, waits for the returned word, and decodes it. Each walk ends in one result pulse on the result port.

If the entry is marked present and its rights allow the requested access, the result carries the physical page number taken from the entry and the unchanged offset. Otherwise it reports a fault and names the cause: page not present, or a rights violation. A store may only be committed when its translation succeeds, and a dedicated commit output says so.

Each process has its own table, so a context switch is a write to the base register. A write that arrives while a walk is in flight is parked and takes effect once the walker is idle again, so the walk in progress keeps the table it started with.

Top module: `ptw_top`

## Requirements
- R1: The read address of a walk equals the base register value plus the virtual page number times 4.
- R2: A base write issued while idle applies to the next walk. A base write issued during a walk leaves that walk on the old table and applies to every later walk.
- R3: An entry whose bit 31 is 0 yields a fault with cause 01 (not present), whatever its rights bits hold.
- R4: For a present entry, rights bits 30:29 decide access: 00 permits load only, 01 permits load and store, 10 permits fetch only, 11 permits nothing. Access codes are 00 load, 01 store, 10 fetch; code 11 is never permitted. A refused access yields a fault with cause 10 (protection).
- R5: A permitted access yields no fault, cause 00, the physical page number equal to entry bits 19:0 and the offset equal to the request offset.
- R6: Every accepted request produces exactly one single-cycle result pulse; requests are accepted only while the walker is idle.
- R7: The store commit output is high only on the result of a permitted store, and low on every faulting result.
- R8: After reset the walker is idle and ready, drives no memory read and no result, and the base register holds 0.
- R9: Once a memory read is raised it stays raised, with a steady address, until the memory accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker accepts a request this cycle |
| req_vpn | input | 20 | Virtual page number |
| req_off | input | 12 | Page offset, passed through |
| req_acc | input | 2 | Access kind: 00 load, 01 store, 10 fetch |
| base_we | input | 1 | Base register write strobe |
| base_wdata | input | 32 | New base register value |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned entry |
| res_valid | output | 1 | Result pulse |
| res_fault | output | 1 | Walk faulted |
| res_cause | output | 2 | 00 none, 01 not present, 10 protection |
| res_ppn | output | 20 | Physical page number |
| res_off | output | 12 | Page offset |
| res_wr_commit | output | 1 | Store may complete |

## Verification
The bench targets the full rights-by-access matrix, including the reserved rights code and the unused access code; a decoder that treated either as permissive would return a translation and raise the commit strobe where a protection fault is due. Absent entries carry rights that would otherwise allow the access, so a walker that checked rights before presence would report the wrong cause. A base write lands in the middle of a long memory stall; a design that applied it at once would read the wrong table for the next walk or corrupt the one in flight, and one that dropped it would leave the next walk on the old table. Memory stalls and latencies vary so that an address that moves during a stall or a doubled result pulse shows up as a miscompare.

// File: rtl/ptw_pkg.sv
// Package: shared types and entry field positions for the page table walker.
// Assumes 32-bit entries with the present flag at the top and rights below it.
package ptw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_READ_REQ  = 2'd1,
        ST_WAIT_DATA = 2'd2,
        ST_RESPOND   = 2'd3
    } walk_state_t;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_NONE  = 2'b11
    } access_t;

    typedef enum logic [1:0] {
        RGT_RO   = 2'b00,
        RGT_RW   = 2'b01,
        RGT_EXEC = 2'b10,
        RGT_RSVD = 2'b11
    } rights_t;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'b00,
        CAUSE_ABSENT = 2'b01,
        CAUSE_PROT   = 2'b10
    } cause_t;

    localparam int ENTRY_W    = 32;
    localparam int PRESENT_B  = 31;
    localparam int RIGHTS_LSB = 29;

endpackage

// File: rtl/ptw_base_reg.sv
// Module: table base register with deferred update.
// Assumes writes arriving while the walker is busy must not disturb the walk
// in flight; the last such write is parked and applied once idle.
module ptw_base_reg #(
    parameter int          ADDR_W   = 32,
    parameter logic [31:0] BASE_RST = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    output logic [ADDR_W-1:0] base_q,
    output logic              hold_off
);

    logic              pend_q;
    logic [ADDR_W-1:0] pend_data_q;

    // Update the base when idle, otherwise park the newest write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q      <= BASE_RST[ADDR_W-1:0];
            pend_q      <= 1'b0;
            pend_data_q <= '0;
        end else if (idle) begin
            if (base_we) begin
                base_q <= base_wdata;
                pend_q <= 1'b0;
            end else if (pend_q) begin
                base_q <= pend_data_q;
                pend_q <= 1'b0;
            end
        end else if (base_we) begin
            pend_q      <= 1'b1;
            pend_data_q <= base_wdata;
        end
    end

    // Block new walks during the cycle in which the base changes.
    always_comb hold_off = idle && (base_we || pend_q);

endmodule

// File: rtl/ptw_addr_gen.sv
// Module: entry address generator.
// Assumes entries are 2**IDX_SHIFT bytes apart, indexed by page number.
module ptw_addr_gen #(
    parameter int ADDR_W    = 32,
    parameter int VPN_W     = 20,
    parameter int IDX_SHIFT = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [VPN_W-1:0]  vpn,
    output logic [ADDR_W-1:0] entry_addr
);

    localparam int PAD_W = ADDR_W - VPN_W;

    logic [ADDR_W-1:0] vpn_ext;

    // Widen the page number and scale it by the entry size.
    always_comb begin
        vpn_ext    = {{PAD_W{1'b0}}, vpn};
        entry_addr = base + (vpn_ext << IDX_SHIFT);
    end

endmodule

// File: rtl/ptw_entry_check.sv
// Module: entry decoder and permission check.
// Assumes presence is tested before rights, so an absent entry always
// reports not-present.
module ptw_entry_check
    import ptw_pkg::*;
#(
    parameter int PPN_W = 20
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic [1:0]         acc,
    output logic [PPN_W-1:0]   ppn,
    output logic [1:0]         cause,
    output logic               fault
);

    logic    present;
    rights_t rights;
    logic    permit;

    // Split the entry into its fields.
    always_comb begin
        present = entry[PRESENT_B];
        rights  = rights_t'(entry[RIGHTS_LSB+1:RIGHTS_LSB]);
        ppn     = entry[PPN_W-1:0];
    end

    // Rights against access kind.
    always_comb begin
        unique case (access_t'(acc))
            ACC_LOAD:  permit = (rights == RGT_RO) || (rights == RGT_RW);
            ACC_STORE: permit = (rights == RGT_RW);
            ACC_FETCH: permit = (rights == RGT_EXEC);
            default:   permit = 1'b0;
        endcase
    end

    // Presence first, then protection.
    always_comb begin
        if (!present)     cause = CAUSE_ABSENT;
        else if (!permit) cause = CAUSE_PROT;
        else              cause = CAUSE_NONE;
        fault = (cause != CAUSE_NONE);
    end

endmodule

// File: rtl/ptw_fsm.sv
// Module: walk sequencer: idle, issue read, wait for data, respond.
// Assumes the memory returns exactly one response per accepted read.
module ptw_fsm
    import ptw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic hold_off,
    input  logic mem_rd_ready,
    input  logic mem_rsp_valid,
    output logic idle,
    output logic accept,
    output logic take_rsp,
    output logic rd_valid,
    output logic respond
);

    walk_state_t st_q, st_d;

    // Handshake decodes for the current state.
    always_comb begin
        idle     = (st_q == ST_IDLE);
        accept   = idle && !hold_off && req_valid;
        rd_valid = (st_q == ST_READ_REQ);
        take_rsp = (st_q == ST_WAIT_DATA) && mem_rsp_valid;
        respond  = (st_q == ST_RESPOND);
    end

    // Next-state selection.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:      if (accept)       st_d = ST_READ_REQ;
            ST_READ_REQ:  if (mem_rd_ready) st_d = ST_WAIT_DATA;
            ST_WAIT_DATA: if (mem_rsp_valid) st_d = ST_RESPOND;
            default:                        st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/ptw_top.sv
// Module: single-level page table walker top.
// Assumes one walk at a time and a memory that answers every accepted read.
module ptw_top
    import ptw_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          VPN_W     = 20,
    parameter int          OFF_W     = 12,
    parameter int          PPN_W     = 20,
    parameter int          IDX_SHIFT = 2,
    parameter logic [31:0] BASE_RST  = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [1:0]        req_acc,
    input  logic              base_we,
    input  logic [ADDR_W-1:0] base_wdata,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [ENTRY_W-1:0] mem_rsp_data,
    output logic              res_valid,
    output logic              res_fault,
    output logic [1:0]        res_cause,
    output logic [PPN_W-1:0]  res_ppn,
    output logic [OFF_W-1:0]  res_off,
    output logic              res_wr_commit
);

    logic              idle, accept, take_rsp, respond, hold_off;
    logic [ADDR_W-1:0] base_q;
    logic [VPN_W-1:0]  vpn_q;
    logic [OFF_W-1:0]  off_q;
    logic [1:0]        acc_q;
    logic [PPN_W-1:0]  chk_ppn;
    logic [1:0]        chk_cause;
    logic              chk_fault;
    logic [PPN_W-1:0]  ppn_q;
    logic [1:0]        cause_q;
    logic              fault_q;

    ptw_base_reg #(.ADDR_W(ADDR_W), .BASE_RST(BASE_RST)) base_i (
        .clk(clk), .rst_n(rst_n), .idle(idle), .base_we(base_we),
        .base_wdata(base_wdata), .base_q(base_q), .hold_off(hold_off)
    );

    ptw_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .hold_off(hold_off),
        .mem_rd_ready(mem_rd_ready), .mem_rsp_valid(mem_rsp_valid),
        .idle(idle), .accept(accept), .take_rsp(take_rsp),
        .rd_valid(mem_rd_valid), .respond(respond)
    );

    ptw_addr_gen #(.ADDR_W(ADDR_W), .VPN_W(VPN_W), .IDX_SHIFT(IDX_SHIFT)) addr_i (
        .base(base_q), .vpn(vpn_q), .entry_addr(mem_rd_addr)
    );

    ptw_entry_check #(.PPN_W(PPN_W)) chk_i (
        .entry(mem_rsp_data), .acc(acc_q), .ppn(chk_ppn),
        .cause(chk_cause), .fault(chk_fault)
    );

    // Capture the request fields when a walk is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q <= '0;
            off_q <= '0;
            acc_q <= 2'b00;
        end else if (accept) begin
            vpn_q <= req_vpn;
            off_q <= req_off;
            acc_q <= req_acc;
        end
    end

    // Capture the decoded entry when memory answers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ppn_q   <= '0;
            cause_q <= CAUSE_NONE;
            fault_q <= 1'b0;
        end else if (take_rsp) begin
            ppn_q   <= chk_ppn;
            cause_q <= chk_cause;
            fault_q <= chk_fault;
        end
    end

    // Drive the request handshake and the result port.
    always_comb begin
        req_ready     = idle && !hold_off;
        res_valid     = respond;
        res_fault     = respond && fault_q;
        res_cause     = respond ? cause_q : CAUSE_NONE;
        res_ppn       = (respond && !fault_q) ? ppn_q : '0;
        res_off       = respond ? off_q : '0;
        res_wr_commit = respond && !fault_q && (acc_q == ACC_STORE);
    end

endmodule

// File: rtl/ptw_checker.sv
// Module: temporal checks on the walker ports, bound into ptw_top.
module ptw_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_rd_valid,
    input logic              mem_rd_ready,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rsp_valid,
    input logic              res_valid,
    input logic              res_fault,
    input logic [1:0]        res_cause,
    input logic              res_wr_commit
);

    logic [1:0] open_q;

    // Count walks accepted but not yet answered.
    always_ff @(posedge clk) begin
        if (!rst_n) open_q <= 2'd0;
        else if ((req_valid && req_ready) && !res_valid) open_q <= open_q + 2'd1;
        else if (!(req_valid && req_ready) && res_valid) open_q <= open_q - 2'd1;
    end

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

    // R6
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R6
    single_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_q <= 2'd1);

    // R6
    idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_rd_valid && !res_valid);

    // R6
    rsp_before_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> $past(mem_rsp_valid));

    // R7
    no_fault_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr_commit |-> res_valid && !res_fault && res_cause == 2'b00);

    // R3
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_fault |-> res_cause != 2'b00);

endmodule

bind ptw_top ptw_checker #(.ADDR_W(ADDR_W)) ptw_chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
    .res_valid(res_valid), .res_fault(res_fault), .res_cause(res_cause),
    .res_wr_commit(res_wr_commit)
);

// File: tb/ptw_top_tb_top.sv
module ptw_top_tb_top;

    typedef struct packed {
        logic        fault;
        logic [1:0]  cause;
        logic [19:0] ppn;
        logic [11:0] off;
        logic        commit;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_vpn = '0;
    logic [11:0] req_off = '0;
    logic [1:0]  req_acc = '0;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        res_valid, res_fault, res_wr_commit;
    logic [1:0]  res_cause;
    logic [19:0] res_ppn;
    logic [11:0] res_off;

    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc = 0;
    int   stall_cyc = 0;
    int   lat_cyc = 0;
    logic [31:0] base_model = 32'h0;
    logic [31:0] pt_mem [1024];
    exp_t        exp_q [$];
    logic [31:0] addr_q [$];

    ptw_top dut_i (.*);

    always #5 clk = ~clk;

    // Watchdog and cycle count.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual cycles %0d expected under 100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [31:0] mk(input logic v, input logic [1:0] r,
                                       input logic [19:0] p);
        return {v, r, 9'b0, p};
    endfunction

    // Expected result from the requirement text (R3, R4, R5, R7).
    function automatic exp_t predict(input logic [31:0] e, input logic [1:0] acc,
                                     input logic [11:0] off);
        exp_t x;
        logic ok;
        case (acc)
            2'b00:   ok = (e[30:29] == 2'b00) || (e[30:29] == 2'b01);
            2'b01:   ok = (e[30:29] == 2'b01);
            2'b10:   ok = (e[30:29] == 2'b10);
            default: ok = 1'b0;
        endcase
        x.off = off;
        if (!e[31]) begin
            x.fault = 1'b1; x.cause = 2'b01; x.ppn = '0; x.commit = 1'b0;
        end else if (!ok) begin
            x.fault = 1'b1; x.cause = 2'b10; x.ppn = '0; x.commit = 1'b0;
        end else begin
            x.fault = 1'b0; x.cause = 2'b00; x.ppn = e[19:0];
            x.commit = (acc == 2'b01);
        end
        return x;
    endfunction

    // Driver: push expectations, then present the request until accepted.
    task automatic walk(input logic [19:0] vpn, input logic [11:0] off,
                        input logic [1:0] acc);
        logic [31:0] a;
        @(negedge clk);
        a = base_model + {10'b0, vpn, 2'b00};
        addr_q.push_back(a);
        exp_q.push_back(predict(pt_mem[a[11:2]], acc, off));
        req_vpn = vpn; req_off = off; req_acc = acc; req_valid = 1'b1;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic set_base(input logic [31:0] v);
        @(negedge clk);
        base_we = 1'b1; base_wdata = v; base_model = v;
        @(negedge clk);
        base_we = 1'b0;
    endtask

    task automatic check(input bit ok, input string rq, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // Memory model: address check (R1), stall hold check (R9), response.
    initial begin
        logic [31:0] a, ea;
        forever begin
            @(negedge clk);
            if (rst_n && mem_rd_valid) begin
                a = mem_rd_addr;
                ea = (addr_q.size() > 0) ? addr_q.pop_front() : 32'hDEAD_BEEF;
                check(a == ea, "R1 entry address", 64'(a), 64'(ea));
                for (int s = 0; s < stall_cyc; s++) begin
                    @(negedge clk);
                    check(mem_rd_valid && mem_rd_addr == a, "R9 read held",
                          {31'b0, mem_rd_valid, mem_rd_addr}, {32'h1, a});
                end
                mem_rd_ready = 1'b1;
                @(negedge clk);
                mem_rd_ready = 1'b0;
                for (int l = 0; l < lat_cyc; l++) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data = pt_mem[a[11:2]];
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    // Monitor: scoreboard compare of every result pulse (R5, R6, R7).
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            exp_t e, g;
            g = {res_fault, res_cause, res_ppn, res_off, res_wr_commit};
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected result", 64'(g), 64'(0));
            end else begin
                e = exp_q.pop_front();
                check(g == e, "R3/R4/R5/R7 result", 64'(g), 64'(e));
            end
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++)
            pt_mem[i] = mk(i[0] ^ i[3], 2'(i >> 1), 20'(i * 37 + 5));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state at the ports
        check(req_ready == 1'b1 && res_valid == 1'b0 && mem_rd_valid == 1'b0,
              "R8 reset state", {61'b0, req_ready, res_valid, mem_rd_valid},
              64'h4);
        // R8: base starts at 0, R5 pass-through of ppn and offset
        pt_mem[3] = mk(1'b1, 2'b01, 20'hABCDE);
        walk(20'd3, 12'h123, 2'b00);
        // R4 / R7 rights matrix on a second table
        set_base(32'h400);
        pt_mem[256 + 1] = mk(1'b1, 2'b01, 20'h11111);
        pt_mem[256 + 2] = mk(1'b1, 2'b00, 20'h22222);
        pt_mem[256 + 4] = mk(1'b1, 2'b10, 20'h44444);
        pt_mem[256 + 5] = mk(1'b1, 2'b11, 20'h55555);
        pt_mem[256 + 6] = mk(1'b0, 2'b01, 20'h66666);
        pt_mem[256 + 7] = mk(1'b0, 2'b10, 20'h77777);
        walk(20'd1, 12'hF01, 2'b01);   // R7 permitted store commits
        walk(20'd2, 12'h002, 2'b01);   // R4 R7 store on read-only
        walk(20'd2, 12'h003, 2'b00);   // R4 load on read-only
        walk(20'd4, 12'h004, 2'b10);   // R4 fetch on exec
        walk(20'd4, 12'h005, 2'b00);   // R4 load on exec
        walk(20'd1, 12'h006, 2'b10);   // R4 fetch on read/write
        walk(20'd5, 12'h007, 2'b00);   // R4 reserved rights
        walk(20'd1, 12'h008, 2'b11);   // R4 unused access code
        walk(20'd6, 12'h009, 2'b01);   // R3 absent with permissive rights
        walk(20'd7, 12'h00A, 2'b10);   // R3 absent exec page
        // R2 process switch: same page number, other table
        set_base(32'h800);
        pt_mem[512 + 1] = mk(1'b1, 2'b01, 20'h99999);
        walk(20'd1, 12'h0B0, 2'b00);
        // R2 deferred write during a long stall
        pt_mem[768 + 1] = mk(1'b1, 2'b10, 20'hCCCCC);
        stall_cyc = 8;
        fork
            walk(20'd1, 12'h0C0, 2'b00);
            begin
                repeat (4) @(negedge clk);
                set_base(32'hC00);
            end
        join
        stall_cyc = 0;
        walk(20'd1, 12'h0D0, 2'b10);   // R2 later walk on new table
        // R6 R9 mixed traffic with varying stalls and latencies
        for (int k = 0; k < 40; k++) begin
            stall_cyc = k % 3;
            lat_cyc = (k / 3) % 3;
            if (k % 10 == 9) set_base(32'(k % 4) << 10);
            walk(20'($urandom_range(0, 200)), 12'(k * 97), 2'(k % 4));
        end
        for (int w = 0; w < 200 && (exp_q.size() > 0 || addr_q.size() > 0); w++)
            @(negedge clk);
        check(exp_q.size() == 0, "R6 results outstanding", 64'(exp_q.size()), 64'(0));
        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule